// File: doc/BRIEF.md
# Wide Row Byte-Shuffle Unit

This block is a one-clock data-rearrangement stage for a wide datapath. Each clock it works on rows of `ROW_BYTES` bytes, 64 by default. Up to three independent function slots run side by side in that clock. Each slot picks one of eight row-wide sources: two memory read rows, two forwarded result rows, or one of the unit's own four result registers. It then applies one operation and writes the outcome into one of the four result registers.

There are five operations:
- pass-through;
- whole-row byte rotation over a fixed set of distances;
- group broadcast, which fans one byte out across its aligned group to expand weights;
- pooling compression, which keeps the maximum of each 2-byte or 4-byte group;
- byte-masked merge, where another result register supplies the per-byte select.

No arithmetic beyond the byte maximum is done. The memories that feed the row inputs lie outside the block. `ROW_BYTES` must be a power of two, at least 4.

Top module: `shuffle_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, all four result registers become zero.
- R2: Slot s takes its command from `slot_cmd[16s+15:16s]`:
  - bit 15 is the enable;
  - bits 14:12 are the op: 0 pass, 1 rotate, 2 broadcast, 3 compress, 4 merge;
  - bits 11:9 are the source: 0 `rd_a_row`, 1 `rd_b_row`, 2 `fwd_a_row`, 3 `fwd_b_row`, 4+k result register k;
  - bits 8:7 are the destination register;
  - bits 6:4 are the argument;
  - bits 3:2 are the merge base register;
  - bits 1:0 are the merge mask register.
  
  A pass writes the selected source unchanged.
- R3: Rotate with argument a in 0..6 moves byte i to byte (i + 2^a) mod `ROW_BYTES`.
- R4: Rotate with argument 7 moves byte i to byte (i - 1) mod `ROW_BYTES`.
- R5: Broadcast with argument a uses group size G = min(2^a, `ROW_BYTES`). Every byte takes the value of the lowest byte of its aligned G-byte group.
- R6: Compress with argument bit 0 clear writes, into byte j, the unsigned maximum of source bytes 2j and 2j+1, for j below `ROW_BYTES`/2. With bit 0 set it writes the maximum of bytes 4j to 4j+3, for j below `ROW_BYTES`/4. All higher bytes become zero.
- R7: Merge byte i is the source byte when bit 7 of byte i of the mask register is set. Otherwise it is byte i of the base register.
- R8: All enabled slots act in the same clock, and every slot reads the register values held before that edge.
- R9: When several enabled slots name the same destination, the lowest-numbered slot's result is written.
- R10: A disabled slot, or a slot whose op is 5, 6 or 7, writes nothing. A register that no valid slot targets keeps its value.
- R11: A command presented before a rising edge shows its result on `out_rows` right after that edge. Before that edge the output is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_row | input | ROW_BYTES*8 | First memory read row (source 0) |
| rd_b_row | input | ROW_BYTES*8 | Second memory read row (source 1) |
| fwd_a_row | input | ROW_BYTES*8 | First forwarded row (source 2) |
| fwd_b_row | input | ROW_BYTES*8 | Second forwarded row (source 3) |
| slot_cmd | input | NUM_SLOTS*16 | Per-slot command words, slot 0 in the low bits |
| out_rows | output | 4*ROW_BYTES*8 | Result registers; byte i of register k at bits (k*ROW_BYTES+i)*8 +: 8 |

## Verification
The bench builds the unit with `ROW_BYTES` = 32 and the default three slots. With that row width, rotation by 32 and by 64 both wrap to a full turn. Broadcast with arguments 5, 6 and 7 all saturate to the whole row. Compression leaves exactly 16 or 8 live bytes, so every wrap and clamp path in the distance and group tables is reached with rows short enough to predict byte by byte.

// File: rtl/shuffle_pkg.sv
package shuffle_pkg;

  localparam int N_REG = 4;
  localparam int N_SRC = 8;
  localparam int REG_W = 2;
  localparam int SRC_W = 3;
  localparam int ARG_W = 3;

  typedef enum logic [2:0] {
    OP_PASS  = 3'd0,
    OP_ROT   = 3'd1,
    OP_BCAST = 3'd2,
    OP_COMP  = 3'd3,
    OP_MERGE = 3'd4
  } shuf_op_e;

  typedef struct packed {
    logic             en;
    logic [2:0]       op;
    logic [SRC_W-1:0] src;
    logic [REG_W-1:0] dst;
    logic [ARG_W-1:0] arg;
    logic [REG_W-1:0] base;
    logic [REG_W-1:0] mask;
  } slot_cmd_t;

endpackage

// File: rtl/row_src_mux.sv
module row_src_mux #(
  parameter int ROW_W = 512,
  parameter int NUM   = 8,
  localparam int SEL_W = $clog2(NUM)
) (
  input  logic [NUM-1:0][ROW_W-1:0] srcs,
  input  logic [SEL_W-1:0]          sel,
  output logic [ROW_W-1:0]          row
);
  assign row = srcs[sel];
endmodule

// File: rtl/byte_rotator.sv
module byte_rotator #(
  parameter int ROW_BYTES = 64,
  localparam int RW = ROW_BYTES * 8
) (
  input  logic [RW-1:0] din,
  input  logic [2:0]    dist_sel,
  output logic [RW-1:0] dout
);
  for (genvar i = 0; i < ROW_BYTES; i++) begin : g_byte
    logic [7:0] cand [8];
    for (genvar k = 0; k < 8; k++) begin : g_dist
      // step 7 is the backward single-byte move, the rest are forward powers of two
      localparam int STEP = (k == 7) ? ROW_BYTES - 1 : ((1 << k) % ROW_BYTES);
      localparam int FROM = (i + ROW_BYTES - STEP) % ROW_BYTES;
      assign cand[k] = din[FROM*8 +: 8];
    end
    assign dout[i*8 +: 8] = cand[dist_sel];
  end
endmodule

// File: rtl/byte_broadcaster.sv
module byte_broadcaster #(
  parameter int ROW_BYTES = 64,
  localparam int RW = ROW_BYTES * 8
) (
  input  logic [RW-1:0] din,
  input  logic [2:0]    grp_sel,
  output logic [RW-1:0] dout
);
  for (genvar i = 0; i < ROW_BYTES; i++) begin : g_byte
    logic [7:0] cand [8];
    for (genvar k = 0; k < 8; k++) begin : g_grp
      localparam int RAW  = 1 << k;
      localparam int GRP  = (RAW > ROW_BYTES) ? ROW_BYTES : RAW;
      localparam int LEAD = (i / GRP) * GRP;
      assign cand[k] = din[LEAD*8 +: 8];
    end
    assign dout[i*8 +: 8] = cand[grp_sel];
  end
endmodule

// File: rtl/row_op_unit.sv
module row_op_unit
  import shuffle_pkg::*;
#(
  parameter int ROW_BYTES = 64,
  localparam int RW = ROW_BYTES * 8
) (
  input  logic [RW-1:0]    src_row,
  input  logic [RW-1:0]    base_row,
  input  logic [RW-1:0]    mask_row,
  input  logic [2:0]       op,
  input  logic [ARG_W-1:0] arg,
  output logic             op_ok,
  output logic [RW-1:0]    result
);
  logic [RW-1:0] rot_row, bc_row, pair_row, quad_row, merge_row;

  byte_rotator #(.ROW_BYTES(ROW_BYTES)) i_rot (
    .din(src_row), .dist_sel(arg), .dout(rot_row));

  byte_broadcaster #(.ROW_BYTES(ROW_BYTES)) i_bc (
    .din(src_row), .grp_sel(arg), .dout(bc_row));

  function automatic logic [7:0] bmax(input logic [7:0] a, input logic [7:0] b);
    return (a > b) ? a : b;
  endfunction

  for (genvar j = 0; j < ROW_BYTES; j++) begin : g_pool
    if (j < ROW_BYTES / 2) begin : g_pair
      assign pair_row[j*8 +: 8] = bmax(src_row[(2*j)*8 +: 8], src_row[(2*j+1)*8 +: 8]);
    end else begin : g_pair_zero
      assign pair_row[j*8 +: 8] = 8'h00;
    end
    if (j < ROW_BYTES / 4) begin : g_quad
      assign quad_row[j*8 +: 8] =
        bmax(bmax(src_row[(4*j)*8 +: 8],   src_row[(4*j+1)*8 +: 8]),
             bmax(src_row[(4*j+2)*8 +: 8], src_row[(4*j+3)*8 +: 8]));
    end else begin : g_quad_zero
      assign quad_row[j*8 +: 8] = 8'h00;
    end
    assign merge_row[j*8 +: 8] = mask_row[j*8 + 7] ? src_row[j*8 +: 8] : base_row[j*8 +: 8];
  end

  always_comb begin
    op_ok  = 1'b1;
    result = src_row;
    case (op)
      OP_PASS:  result = src_row;
      OP_ROT:   result = rot_row;
      OP_BCAST: result = bc_row;
      OP_COMP:  result = arg[0] ? quad_row : pair_row;
      OP_MERGE: result = merge_row;
      default: begin
        op_ok  = 1'b0;
        result = '0;
      end
    endcase
  end
endmodule

// File: rtl/shuffle_unit.sv
module shuffle_unit
  import shuffle_pkg::*;
#(
  parameter int ROW_BYTES = 64,
  parameter int NUM_SLOTS = 3,
  localparam int RW    = ROW_BYTES * 8,
  localparam int CMD_W = $bits(slot_cmd_t)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [RW-1:0]            rd_a_row,
  input  logic [RW-1:0]            rd_b_row,
  input  logic [RW-1:0]            fwd_a_row,
  input  logic [RW-1:0]            fwd_b_row,
  input  logic [NUM_SLOTS*CMD_W-1:0] slot_cmd,
  output logic [N_REG*RW-1:0]      out_rows
);
  logic [N_REG-1:0][RW-1:0]     regs_q, regs_d;
  logic [N_SRC-1:0][RW-1:0]     srcs;
  logic [NUM_SLOTS-1:0]         wr;
  logic [NUM_SLOTS-1:0][RW-1:0] res;
  logic [NUM_SLOTS-1:0][REG_W-1:0] dst;
  logic [NUM_SLOTS-1:0][2:0]    opc;
  logic [N_REG-1:0]             hit;

  assign srcs[0] = rd_a_row;
  assign srcs[1] = rd_b_row;
  assign srcs[2] = fwd_a_row;
  assign srcs[3] = fwd_b_row;
  for (genvar k = 0; k < N_REG; k++) begin : g_fb
    assign srcs[4+k] = regs_q[k];
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    slot_cmd_t     c;
    logic [RW-1:0] sel_row;
    logic          ok;
    assign c = slot_cmd[s*CMD_W +: CMD_W];

    row_src_mux #(.ROW_W(RW), .NUM(N_SRC)) i_mux (
      .srcs(srcs), .sel(c.src), .row(sel_row));

    row_op_unit #(.ROW_BYTES(ROW_BYTES)) i_op (
      .src_row(sel_row), .base_row(regs_q[c.base]), .mask_row(regs_q[c.mask]),
      .op(c.op), .arg(c.arg), .op_ok(ok), .result(res[s]));

    assign wr[s]  = c.en & ok;
    assign dst[s] = c.dst;
    assign opc[s] = c.op;
  end

  // highest slot first so the lowest enabled slot overwrites last
  always_comb begin
    regs_d = regs_q;
    for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
      if (wr[s]) regs_d[dst[s]] = res[s];
    end
  end

  always_comb begin
    hit = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (wr[s]) hit[dst[s]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) regs_q <= '0;
    else     regs_q <= regs_d;
  end

  assign out_rows = regs_q;

  // slot 0 view for the properties below
  logic [REG_W-1:0] s0_mask_reg, s0_base_reg;
  assign s0_mask_reg = g_slot[0].c.mask;
  assign s0_base_reg = g_slot[0].c.base;

  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (out_rows == '0));

  p_slot0_wins_r9: assert property (@(posedge clk) disable iff (rst)
    wr[0] |=> (regs_q[$past(dst[0])] == $past(res[0])));

  p_merge_keep_r7: assert property (@(posedge clk) disable iff (rst)
    (wr[0] && opc[0] == OP_MERGE && !regs_q[s0_mask_reg][7])
      |=> (regs_q[$past(dst[0])][7:0] == $past(regs_q[s0_base_reg][7:0])));

  p_compress_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (wr[0] && opc[0] == OP_COMP) |=> (regs_q[$past(dst[0])][RW-1 -: RW/2] == '0));

  for (genvar k = 0; k < N_REG; k++) begin : g_hold_chk
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
      !hit[k] |=> $stable(regs_q[k]));
  end
endmodule

// File: tb/test_shuffle_unit.sv
module test_shuffle_unit;
  localparam int RB = 32;
  localparam int RW = RB * 8;
  localparam int NS = 3;
  localparam int NV = 17;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [RW-1:0] rd_a_row, rd_b_row, fwd_a_row, fwd_b_row;
  logic [NS*16-1:0] slot_cmd = '0;
  logic [4*RW-1:0] out_rows;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  logic [3:0][RW-1:0] model;

  always #2 clk = ~clk;
  always @(posedge clk) cyc++;

  shuffle_unit #(.ROW_BYTES(RB), .NUM_SLOTS(NS)) i_shuffle_unit (
    .clk(clk), .rst(rst), .rd_a_row(rd_a_row), .rd_b_row(rd_b_row),
    .fwd_a_row(fwd_a_row), .fwd_b_row(fwd_b_row), .slot_cmd(slot_cmd),
    .out_rows(out_rows));

  function automatic logic [15:0] mk(input logic en, input logic [2:0] op, input logic [2:0] src,
                                     input logic [1:0] dst, input logic [2:0] arg,
                                     input logic [1:0] base, input logic [1:0] mask);
    return {en, op, src, dst, arg, base, mask};
  endfunction

  localparam logic [15:0] Z = 16'h0000;
  localparam logic [NS*16-1:0] VEC [NV] = '{
    {Z, Z, mk(1, 0, 0, 0, 0, 0, 0)},                       // R2 pass rd_a -> r0
    {Z, Z, mk(1, 0, 1, 1, 0, 0, 0)},                       // R2 pass rd_b -> r1
    {Z, Z, mk(1, 1, 0, 2, 0, 0, 0)},                       // R3 rotate +1
    {Z, Z, mk(1, 1, 4, 3, 3, 0, 0)},                       // R3 rotate r0 +8
    {Z, Z, mk(1, 1, 0, 2, 5, 0, 0)},                       // R3 rotate +32 wraps
    {Z, Z, mk(1, 1, 1, 3, 7, 0, 0)},                       // R4 rotate -1
    {Z, Z, mk(1, 2, 0, 1, 2, 0, 0)},                       // R5 broadcast groups of 4
    {Z, Z, mk(1, 2, 2, 1, 6, 0, 0)},                       // R5 broadcast clamps to row
    {Z, Z, mk(1, 3, 1, 2, 0, 0, 0)},                       // R6 compress pairs
    {Z, Z, mk(1, 3, 3, 3, 1, 0, 0)},                       // R6 compress quads
    {Z, Z, mk(1, 0, 3, 0, 0, 0, 0)},                       // R2 pass fwd_b -> r0 (mask)
    {Z, Z, mk(1, 4, 0, 1, 0, 2, 0)},                       // R7 merge rd_a over r2 by r0
    {mk(1, 3, 5, 2, 1, 0, 0), mk(1, 2, 4, 1, 1, 0, 0), mk(1, 1, 0, 0, 1, 0, 0)}, // R8 three at once
    {mk(1, 1, 2, 3, 0, 0, 0), mk(1, 0, 1, 3, 0, 0, 0), mk(1, 0, 0, 3, 0, 0, 0)}, // R9 slot 0 wins
    {mk(1, 0, 2, 1, 0, 0, 0), mk(1, 0, 3, 1, 0, 0, 0), mk(0, 0, 0, 1, 0, 0, 0)}, // R9 slot 1 beats 2
    {Z, mk(0, 0, 1, 2, 0, 0, 0), mk(1, 5, 1, 0, 0, 0, 0)}, // R10 op 5 and disabled
    {Z, Z, Z}                                              // R10 idle
  };
  localparam int VREQ [NV] = '{2, 2, 3, 3, 3, 4, 5, 5, 6, 6, 2, 7, 8, 9, 9, 10, 10};

  function automatic logic [7:0] gb(input logic [RW-1:0] r, input int i);
    return r[i*8 +: 8];
  endfunction

  function automatic logic [RW-1:0] ref_op(input logic [2:0] op, input logic [2:0] arg,
                                           input logic [RW-1:0] s, input logic [RW-1:0] b,
                                           input logic [RW-1:0] m);
    logic [RW-1:0] o;
    int d, g, n;
    logic [7:0] mx;
    o = '0;
    case (op)
      3'd0: o = s;
      3'd1: begin
        d = (arg == 3'd7) ? RB - 1 : (1 << arg);
        for (int i = 0; i < RB; i++) o[((i + d) % RB)*8 +: 8] = gb(s, i);
      end
      3'd2: begin
        g = (1 << arg) > RB ? RB : (1 << arg);
        for (int i = 0; i < RB; i++) o[i*8 +: 8] = gb(s, (i / g) * g);
      end
      3'd3: begin
        n = arg[0] ? 4 : 2;
        for (int j = 0; j < RB / n; j++) begin
          mx = 8'h00;
          for (int t = 0; t < n; t++) if (gb(s, j*n + t) > mx) mx = gb(s, j*n + t);
          o[j*8 +: 8] = mx;
        end
      end
      default: for (int i = 0; i < RB; i++) o[i*8 +: 8] = m[i*8+7] ? gb(s, i) : gb(b, i);
    endcase
    return o;
  endfunction

  function automatic logic [RW-1:0] pick(input logic [2:0] src, input logic [3:0][RW-1:0] regs);
    case (src)
      3'd0: return rd_a_row;
      3'd1: return rd_b_row;
      3'd2: return fwd_a_row;
      3'd3: return fwd_b_row;
      default: return regs[src - 3'd4];
    endcase
  endfunction

  task automatic model_step(input logic [NS*16-1:0] cw);
    logic [3:0][RW-1:0] old;
    logic [15:0] c;
    old = model;
    for (int s = NS - 1; s >= 0; s--) begin
      c = cw[s*16 +: 16];
      if (c[15] && c[14:12] <= 3'd4)
        model[c[8:7]] = ref_op(c[14:12], c[6:4], pick(c[11:9], old), old[c[3:2]], old[c[1:0]]);
    end
  endtask

  task automatic check_row(input int k, input logic [RW-1:0] exp, input string tag);
    checks++;
    if (out_rows[k*RW +: RW] !== exp) begin
      fails++;
      $display("FAIL %s reg%0d actual %h expected %h", tag, k, out_rows[k*RW +: RW], exp);
    end
  endtask

  task automatic check_all(input string tag);
    for (int k = 0; k < 4; k++) check_row(k, model[k], tag);
  endtask

  initial begin
    wait (cyc == 20000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < RB; i++) begin
      rd_a_row[i*8 +: 8]  = 8'(i * 7 + 3);
      rd_b_row[i*8 +: 8]  = 8'(8'hF0 ^ (i * 5));
      fwd_a_row[i*8 +: 8] = 8'(255 - i * 3);
      fwd_b_row[i*8 +: 8] = (i % 3 == 0) ? 8'(8'h80 | i) : 8'(8'h20 + i);
    end
    model = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all("R1 reset");
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      slot_cmd = VEC[v];
      model_step(VEC[v]);
      @(posedge clk);
      @(negedge clk);
      check_all($sformatf("R%0d vec%0d", VREQ[v], v));
    end

    // R11: nothing moves before the edge, the result appears right after it
    slot_cmd = {Z, Z, mk(1, 0, 1, 0, 0, 0, 0)};
    #1;
    check_row(0, model[0], "R11 before edge");
    model_step(slot_cmd);
    @(posedge clk);
    @(negedge clk);
    check_row(0, model[0], "R11 after edge");
    check_row(0, rd_b_row, "R11 value");

    // R1: reset overrides a pending write
    slot_cmd = {mk(1, 0, 2, 2, 0, 0, 0), mk(1, 0, 3, 1, 0, 0, 0), mk(1, 0, 0, 3, 0, 0, 0)};
    rst = 1'b1;
    model = '0;
    @(posedge clk);
    @(negedge clk);
    check_all("R1 mid-run reset");
    rst = 1'b0;
    slot_cmd = '0;
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule